// File: doc/BRIEF.md
# Per-Lane Loopback Path Controller

This block steers word-level data between the host, the serializer, the clock-recovery input and the line driver of a four-lane transceiver. Each lane has its own active loopback mode. The mode selects which source feeds three places: the serializer's parallel input, the transmit line driver and the receive recovery path. The block also gates the transmit pre-emphasis enable. It refuses a parallel loop request while the device carries a protocol rather than raw bypass traffic.

Software writes a 2-bit mode for any subset of lanes through a write-enable mask. The active mode of each lane changes on the following clock edge. From then on, the lane's registered data outputs follow the new routing, with one clock of latency from the data inputs. Per-lane status outputs show the active mode and whether the last request was rejected.

Top module: `lane_loop_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, every lane's active mode becomes normal (00), every error bit clears, and all data outputs and pre-emphasis enables become zero.
- R2: Mode encoding is 00 normal, 01 serial, 10 metallic, 11 parallel. The field for lane i is bits [2i+1:2i] of `cfg_mode` and `act_mode`. When `cfg_we[i]` is high at an edge, lane i's active mode is updated at that edge. Lanes whose enable is low keep their mode.
- R3: In normal mode, one clock after the inputs are presented: `ser_in_word` equals `host_tx_word`, `tx_drv_word` equals `ser_out_word`, `cdr_in_word` equals `line_rx_word`, and `host_rx_word` equals `des_rx_word` in every mode.
- R4: In serial mode, `cdr_in_word` takes `ser_out_word` and ignores `line_rx_word`, while `tx_drv_word` keeps carrying `ser_out_word`.
- R5: In metallic mode, `tx_drv_word` takes `line_rx_word` and ignores `ser_out_word`.
- R6: `emph_en[i]` is registered `emph_req[i]`, forced to 0 whenever lane i's active mode is metallic.
- R7: In parallel mode, `ser_in_word` takes `des_rx_word` and ignores `host_tx_word`.
- R8: A write of parallel mode while `proto_bypass` is 0 is rejected. The lane's active mode becomes normal and its `lb_err` bit becomes 1.
- R9: Any accepted write to a lane clears that lane's `lb_err` bit. Lanes that are not written keep their error bit.
- R10: If a lane is in parallel mode and `proto_bypass` is 0 at an edge with no write to that lane, the lane falls back to normal and its `lb_err` bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| proto_bypass | input | 1 | 1 = raw bypass traffic, 0 = protocol traffic |
| cfg_we | input | LANES | Per-lane mode write enable |
| cfg_mode | input | 2*LANES | Requested modes, 2 bits per lane |
| emph_req | input | LANES | Requested pre-emphasis enable per lane |
| host_tx_word | input | LANES*W | Transmit words from the host |
| des_rx_word | input | LANES*W | Deserialized receive words |
| ser_out_word | input | LANES*W | Serializer output words |
| line_rx_word | input | LANES*W | Receive-buffer words from the line |
| ser_in_word | output | LANES*W | Word fed to the serializer |
| tx_drv_word | output | LANES*W | Word fed to the transmit line driver |
| cdr_in_word | output | LANES*W | Word fed to the recovery path |
| host_rx_word | output | LANES*W | Receive word returned to the host |
| emph_en | output | LANES | Gated pre-emphasis enable |
| act_mode | output | 2*LANES | Active mode per lane |
| lb_err | output | LANES | Rejected-parallel-loop flag per lane |

## Verification
The bench drives a distinct value on every data source in every lane, so a wrong selection shows up as a recognizable wrong word. Several corner cases are targeted. A parallel request under protocol traffic must come out as normal with the error flag set; a design that accepted it would loop receive data into the serializer. Removing bypass while a lane sits in parallel mode must force a fallback; a design without that rule would keep an illegal loop. A write to one lane must leave the others alone; a shared write strobe would disturb them. Pre-emphasis must drop only for the metallic lane, and a design that ungated it would still show the request on that lane.

// File: rtl/lbk_pkg.sv
package lbk_pkg;

  typedef enum logic [1:0] {
    LB_NORMAL   = 2'b00,
    LB_SERIAL   = 2'b01,
    LB_METAL    = 2'b10,
    LB_PARALLEL = 2'b11
  } lb_mode_e;

  // A parallel loop needs raw bypass traffic; all other modes are always legal.
  function automatic logic mode_allowed(input lb_mode_e m, input logic bypass);
    return (m != LB_PARALLEL) || bypass;
  endfunction

endpackage

// File: rtl/lbk_mode_reg.sv
module lbk_mode_reg
  import lbk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [1:0] wr_mode,
  input  logic       bypass,
  output logic [1:0] mode,
  output logic       err
);

  lb_mode_e mode_q, mode_d;
  logic     err_q, err_d;
  lb_mode_e req;

  assign req = lb_mode_e'(wr_mode);

  always_comb begin
    mode_d = mode_q;
    err_d  = err_q;
    if (wr_en) begin
      if (mode_allowed(req, bypass)) begin
        mode_d = req;
        err_d  = 1'b0;
      end else begin
        mode_d = LB_NORMAL;
        err_d  = 1'b1;
      end
    end else if (!mode_allowed(mode_q, bypass)) begin
      // traffic type changed under an active parallel loop
      mode_d = LB_NORMAL;
      err_d  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= LB_NORMAL;
      err_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      err_q  <= err_d;
    end
  end

  assign mode = mode_q;
  assign err  = err_q;

endmodule

// File: rtl/lbk_lane_path.sv
module lbk_lane_path
  import lbk_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   mode,
  input  logic         emph_req,
  input  logic [W-1:0] host_tx,
  input  logic [W-1:0] des_rx,
  input  logic [W-1:0] ser_out,
  input  logic [W-1:0] line_rx,
  output logic [W-1:0] ser_in,
  output logic [W-1:0] tx_drv,
  output logic [W-1:0] cdr_in,
  output logic [W-1:0] host_rx,
  output logic         emph_en
);

  lb_mode_e     m;
  logic [W-1:0] ser_in_d, tx_drv_d, cdr_in_d;
  logic         emph_d;

  assign m = lb_mode_e'(mode);

  always_comb begin
    ser_in_d = (m == LB_PARALLEL) ? des_rx  : host_tx;
    tx_drv_d = (m == LB_METAL)    ? line_rx : ser_out;
    cdr_in_d = (m == LB_SERIAL)   ? ser_out : line_rx;
    emph_d   = emph_req && (m != LB_METAL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_in  <= '0;
      tx_drv  <= '0;
      cdr_in  <= '0;
      host_rx <= '0;
      emph_en <= 1'b0;
    end else begin
      ser_in  <= ser_in_d;
      tx_drv  <= tx_drv_d;
      cdr_in  <= cdr_in_d;
      host_rx <= des_rx;
      emph_en <= emph_d;
    end
  end

endmodule

// File: rtl/lane_loop_ctrl.sv
module lane_loop_ctrl
  import lbk_pkg::*;
#(
  parameter int LANES = 4,
  parameter int W     = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 proto_bypass,
  input  logic [LANES-1:0]     cfg_we,
  input  logic [2*LANES-1:0]   cfg_mode,
  input  logic [LANES-1:0]     emph_req,
  input  logic [LANES*W-1:0]   host_tx_word,
  input  logic [LANES*W-1:0]   des_rx_word,
  input  logic [LANES*W-1:0]   ser_out_word,
  input  logic [LANES*W-1:0]   line_rx_word,
  output logic [LANES*W-1:0]   ser_in_word,
  output logic [LANES*W-1:0]   tx_drv_word,
  output logic [LANES*W-1:0]   cdr_in_word,
  output logic [LANES*W-1:0]   host_rx_word,
  output logic [LANES-1:0]     emph_en,
  output logic [2*LANES-1:0]   act_mode,
  output logic [LANES-1:0]     lb_err
);

  localparam int MW = 2;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [MW-1:0] lane_mode;

    lbk_mode_reg u_mode (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (cfg_we[i]),
      .wr_mode (cfg_mode[MW*i +: MW]),
      .bypass  (proto_bypass),
      .mode    (lane_mode),
      .err     (lb_err[i])
    );

    lbk_lane_path #(.W(W)) u_path (
      .clk      (clk),
      .rst      (rst),
      .mode     (lane_mode),
      .emph_req (emph_req[i]),
      .host_tx  (host_tx_word[W*i +: W]),
      .des_rx   (des_rx_word[W*i +: W]),
      .ser_out  (ser_out_word[W*i +: W]),
      .line_rx  (line_rx_word[W*i +: W]),
      .ser_in   (ser_in_word[W*i +: W]),
      .tx_drv   (tx_drv_word[W*i +: W]),
      .cdr_in   (cdr_in_word[W*i +: W]),
      .host_rx  (host_rx_word[W*i +: W]),
      .emph_en  (emph_en[i])
    );

    assign act_mode[MW*i +: MW] = lane_mode;
  end

endmodule

// File: rtl/lbk_checker.sv
module lbk_checker #(
  parameter int LANES = 4,
  parameter int W     = 10
) (
  input logic               clk,
  input logic               rst,
  input logic               proto_bypass,
  input logic [LANES-1:0]   cfg_we,
  input logic [2*LANES-1:0] cfg_mode,
  input logic [LANES*W-1:0] des_rx_word,
  input logic [LANES*W-1:0] ser_out_word,
  input logic [LANES*W-1:0] line_rx_word,
  input logic [LANES*W-1:0] ser_in_word,
  input logic [LANES*W-1:0] tx_drv_word,
  input logic [LANES*W-1:0] cdr_in_word,
  input logic [LANES-1:0]   emph_en,
  input logic [2*LANES-1:0] act_mode,
  input logic [LANES-1:0]   lb_err
);

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (act_mode == '0 && lb_err == '0 && emph_en == '0));

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
      (!cfg_we[i] && (act_mode[2*i +: 2] != 2'b11 || proto_bypass))
        |=> $stable(act_mode[2*i +: 2]));

    p_serial_r4: assert property (@(posedge clk) disable iff (rst)
      (act_mode[2*i +: 2] == 2'b01)
        |=> cdr_in_word[W*i +: W] == $past(ser_out_word[W*i +: W]));

    p_metal_r5: assert property (@(posedge clk) disable iff (rst)
      (act_mode[2*i +: 2] == 2'b10)
        |=> tx_drv_word[W*i +: W] == $past(line_rx_word[W*i +: W]));

    p_emph_off_r6: assert property (@(posedge clk) disable iff (rst)
      (act_mode[2*i +: 2] == 2'b10) |=> !emph_en[i]);

    p_par_src_r7: assert property (@(posedge clk) disable iff (rst)
      (act_mode[2*i +: 2] == 2'b11)
        |=> ser_in_word[W*i +: W] == $past(des_rx_word[W*i +: W]));

    p_reject_r8: assert property (@(posedge clk) disable iff (rst)
      (cfg_we[i] && cfg_mode[2*i +: 2] == 2'b11 && !proto_bypass)
        |=> (act_mode[2*i +: 2] == 2'b00 && lb_err[i]));

    p_fallback_r10: assert property (@(posedge clk) disable iff (rst)
      (!cfg_we[i] && act_mode[2*i +: 2] == 2'b11 && !proto_bypass)
        |=> (act_mode[2*i +: 2] == 2'b00 && lb_err[i]));
  end

endmodule

bind lane_loop_ctrl lbk_checker #(.LANES(LANES), .W(W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .proto_bypass (proto_bypass),
  .cfg_we       (cfg_we),
  .cfg_mode     (cfg_mode),
  .des_rx_word  (des_rx_word),
  .ser_out_word (ser_out_word),
  .line_rx_word (line_rx_word),
  .ser_in_word  (ser_in_word),
  .tx_drv_word  (tx_drv_word),
  .cdr_in_word  (cdr_in_word),
  .emph_en      (emph_en),
  .act_mode     (act_mode),
  .lb_err       (lb_err)
);

// File: tb/lane_loop_ctrl_tb.sv
module lane_loop_ctrl_tb;
  localparam int LANES = 4;
  localparam int W     = 10;
  localparam int NV    = 8;

  // [11:10] mode, [9] bypass, [8] emph_req, [7:6] exp mode, [5] exp err,
  // [4] exp emph, [3] ser_in from des, [2] tx_drv from line, [1] cdr from ser_out
  localparam logic [11:0] VEC [NV] = '{
    12'b00_0_1_00_0_1_0_0_0_0,
    12'b01_0_1_01_0_1_0_0_1_0,
    12'b10_0_1_10_0_0_0_1_0_0,
    12'b11_1_1_11_0_1_1_0_0_0,
    12'b11_0_1_00_1_1_0_0_0_0,
    12'b10_1_0_10_0_0_0_1_0_0,
    12'b01_1_0_01_0_0_0_0_1_0,
    12'b00_1_1_00_0_1_0_0_0_0
  };

  logic clk = 1'b0;
  logic rst;
  logic proto_bypass;
  logic [LANES-1:0]   cfg_we;
  logic [2*LANES-1:0] cfg_mode;
  logic [LANES-1:0]   emph_req;
  logic [LANES*W-1:0] host_tx_word, des_rx_word, ser_out_word, line_rx_word;
  logic [LANES*W-1:0] ser_in_word, tx_drv_word, cdr_in_word, host_rx_word;
  logic [LANES-1:0]   emph_en;
  logic [2*LANES-1:0] act_mode;
  logic [LANES-1:0]   lb_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  lane_loop_ctrl #(.LANES(LANES), .W(W)) u_dut (.*);

  function automatic logic [W-1:0] w_host(int v, int l); return W'(v*8 + l + 1);   endfunction
  function automatic logic [W-1:0] w_des (int v, int l); return W'(v*8 + l + 200); endfunction
  function automatic logic [W-1:0] w_ser (int v, int l); return W'(v*8 + l + 400); endfunction
  function automatic logic [W-1:0] w_line(int v, int l); return W'(v*8 + l + 600); endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive_data(int v);
    for (int l = 0; l < LANES; l++) begin
      host_tx_word[W*l +: W] = w_host(v, l);
      des_rx_word[W*l +: W]  = w_des(v, l);
      ser_out_word[W*l +: W] = w_ser(v, l);
      line_rx_word[W*l +: W] = w_line(v, l);
    end
  endtask

  // drive config at negedge, one edge to apply, then data and one edge to register
  task automatic step(logic [LANES-1:0] we, logic [1:0] m, logic byp, logic [LANES-1:0] er, int v);
    cfg_we = we;
    cfg_mode = {LANES{m}};
    proto_bypass = byp;
    emph_req = er;
    @(posedge clk); @(negedge clk);
    cfg_we = '0;
    drive_data(v);
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; proto_bypass = 1'b0; cfg_we = '0; cfg_mode = '0; emph_req = '1;
    drive_data(30);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 act_mode", 32'(act_mode), 0);
    chk("R1 lb_err", 32'(lb_err), 0);
    chk("R1 emph_en", 32'(emph_en), 0);
    chk("R1 ser_in", 32'(ser_in_word), 0);
    chk("R1 tx_drv", 32'(tx_drv_word), 0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      logic [11:0] e;
      e = VEC[v];
      step('1, e[11:10], e[9], {LANES{e[8]}}, v);
      for (int l = 0; l < LANES; l++) begin
        chk("R2/R8 mode", 32'(act_mode[2*l +: 2]), 32'(e[7:6]));
        chk("R8/R9 err", 32'(lb_err[l]), 32'(e[5]));
        chk("R6 emph", 32'(emph_en[l]), 32'(e[4]));
        chk("R3/R7 ser_in", 32'(ser_in_word[W*l +: W]),
            32'(e[3] ? w_des(v, l) : w_host(v, l)));
        chk("R3/R5 tx_drv", 32'(tx_drv_word[W*l +: W]),
            32'(e[2] ? w_line(v, l) : w_ser(v, l)));
        chk("R3/R4 cdr_in", 32'(cdr_in_word[W*l +: W]),
            32'(e[1] ? w_ser(v, l) : w_line(v, l)));
        chk("R3 host_rx", 32'(host_rx_word[W*l +: W]), 32'(w_des(v, l)));
      end
    end

    // R2: write only lane 2 to metallic
    step(4'b0100, 2'b10, 1'b1, '1, 20);
    chk("R2 lane mask", 32'(act_mode), 32'(8'b00_10_00_00));
    chk("R5 lane2 tx_drv", 32'(tx_drv_word[W*2 +: W]), 32'(w_line(20, 2)));
    chk("R2 lane0 tx_drv", 32'(tx_drv_word[W*0 +: W]), 32'(w_ser(20, 0)));
    chk("R6 emph mask", 32'(emph_en), 32'(4'b1011));

    // R10: parallel under bypass, then drop bypass without a write
    step('1, 2'b11, 1'b1, '1, 21);
    chk("R7 mode", 32'(act_mode), 32'(8'hFF));
    proto_bypass = 1'b0;
    drive_data(22);
    @(posedge clk); @(negedge clk);
    chk("R7 last par", 32'(ser_in_word[W*1 +: W]), 32'(w_des(22, 1)));
    chk("R10 mode", 32'(act_mode), 0);
    chk("R10 err", 32'(lb_err), 32'(4'hF));
    drive_data(23);
    @(posedge clk); @(negedge clk);
    chk("R10 ser_in", 32'(ser_in_word[W*3 +: W]), 32'(w_host(23, 3)));

    // R9: accepted write to lane 1 clears only its error
    step(4'b0010, 2'b01, 1'b0, '1, 24);
    chk("R9 err", 32'(lb_err), 32'(4'b1101));
    chk("R9 mode", 32'(act_mode), 32'(8'b00_00_01_00));
    chk("R4 lane1 cdr", 32'(cdr_in_word[W*1 +: W]), 32'(w_ser(24, 1)));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule